// File: doc/BRIEF.md
# Telephone Dial Pulse Generator

This block sends the loop-disconnect pulses for one telephone digit on a single output pin. One 8-bit control word sets it up: a start bit, a polarity select, a speed select and a 4-bit pulse count. An accepted start makes the block send the programmed number of pulses. Each pulse is a break interval followed by a make interval, at 10 or 20 pulses per second. After the last make interval the pin goes back to its idle level and a one-cycle done strobe is given.

All timing is counted in ticks of a prescaler. With the defaults one tick is one millisecond. A pulse period is SLOW_TICKS ticks at the slow rate and FAST_TICKS ticks at the fast rate, and BREAK_PCT percent of each period is break. The prescaler restarts on every accepted start, so the first break interval always has its full length.

Two busy inputs come from neighbouring signalling generators, one for tones and one for FSK. A start request made while either input is high is refused and flagged. A start request with a pulse count outside 1..10 is also refused and flagged. Writing the start bit low aborts a pulse train at once.

Top module: `dial_pulse_gen`

## Requirements
- R1: After reset, pulse_out is 0 and busy, done, count_err and lock_err are all 0.
- R2: A write with bit 6 = 1 is accepted as a start when all of these hold: the block is idle, both busy inputs are low, and the count in bits 3:0 is 1 to 10. On the next cycle busy is 1 and pulse_out is at the break level.
- R3: Each pulse is a break interval of BREAK_PCT percent of the period, followed by a make interval for the rest of the period. The number of pulses equals the count written in bits 3:0 (0xA = 10 pulses).
- R4: In the cycle after the last make interval ends, pulse_out returns to the idle level, busy falls and done is 1. Done stays high for exactly one cycle.
- R5: Bit 4 = 0 selects a period of SLOW_TICKS ticks (10 pulses/s). Bit 4 = 1 selects FAST_TICKS ticks (20 pulses/s).
- R6: Bit 5 selects the polarity.
  - With bit 5 = 0, break is low, make is high and idle is low.
  - With bit 5 = 1, break is high, make is low and idle is high.
  - While the block is idle, the pin follows the stored bit 5.
- R7: A start request with a count of 0 or above 10 does not start a train and sets count_err. The flag is re-evaluated on the next start request made while the block is idle.
- R8: A start request while tone_busy or fsk_busy is high does not start a train and sets lock_err. The flag is re-evaluated on the next start request made while the block is idle.
- R9: A write with bit 6 = 0 during a train aborts it. On the next cycle busy is 0 and pulse_out is at the idle level, and done is not given.
- R10: Bit 7 of the control word is reserved and has no effect on the pulse train.
- R11: A write with bit 6 = 1 while a train is running is discarded, and the train continues with its original settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word: bit 6 start, bit 5 polarity, bit 4 speed, bits 3:0 count |
| tone_busy | input | 1 | Tone generator is running |
| fsk_busy | input | 1 | FSK generator is running |
| pulse_out | output | 1 | Dial pulse line output |
| busy | output | 1 | Pulse train in progress |
| done | output | 1 | One-cycle strobe after the last make interval |
| count_err | output | 1 | Last start request had an illegal count |
| lock_err | output | 1 | Last start request collided with a busy generator |

## Verification
The checker watches the control handshakes on every cycle:
- the idle level while the block is not busy, under whichever polarity is stored;
- the break level on the cycle after an accepted start;
- refusal of starts with a bad count or a busy generator, and the error flag each one sets;
- aborts that do not give done;
- done lasting a single cycle.

Only the bench scenarios can show the properties of a whole train. These are the break and make interval lengths in cycles, the total number of pulses for each count and speed, the unchanged train after a discarded write, and the lack of effect of the reserved bit.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

   // Control word bit positions (software encodes these, so they are fixed)
   localparam int BIT_RSVD  = 7;
   localparam int BIT_START = 6;
   localparam int BIT_POL   = 5;
   localparam int BIT_FAST  = 4;
   localparam int CNT_LSB   = 0;
   localparam int CNT_W     = 4;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_BREAK = 2'd1,
      PH_MAKE  = 2'd2
   } dpg_phase_e;

   typedef struct packed {
      logic             pol;
      logic             fast;
      logic [CNT_W-1:0] cnt;
   } dpg_cfg_t;

   function automatic logic count_legal(input logic [CNT_W-1:0] c, input int unsigned max_c);
      return (c != '0) && (int'(c) <= int'(max_c));
   endfunction

endpackage

// File: rtl/dpg_prescaler.sv
module dpg_prescaler #(
   parameter int unsigned TICK_DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   generate
      if (TICK_DIV == 1) begin : g_direct
         logic unused_ok;
         assign unused_ok = ^{clk, rst_n, restart};
         assign tick = 1'b1;
      end else begin : g_count
         localparam int DIV_W = $clog2(TICK_DIV);
         localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
         logic [DIV_W-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (restart || div_q == LAST) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end

         assign tick = (div_q == LAST) && !restart;
      end
   endgenerate

endmodule

// File: rtl/dpg_ctrl.sv
module dpg_ctrl
   import dpg_pkg::*;
#(
   parameter int unsigned MAX_PULSES = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [7:0]       wdata,
   input  logic             seq_busy,
   input  logic             tone_busy,
   input  logic             fsk_busy,
   output dpg_cfg_t         cfg_q,
   output logic             start,
   output logic [CNT_W-1:0] start_cnt,
   output logic             stop,
   output logic             count_err,
   output logic             lock_err
);
   logic             req_start;
   logic             req_stop;
   logic             locked;
   logic             cnt_ok;
   logic             take_write;
   logic [CNT_W-1:0] w_cnt;
   logic             unused_rsvd;

   assign unused_rsvd = wdata[BIT_RSVD];
   assign w_cnt       = wdata[CNT_LSB +: CNT_W];
   assign req_start   = we && wdata[BIT_START];
   assign req_stop    = we && !wdata[BIT_START];
   assign locked      = tone_busy || fsk_busy;
   assign cnt_ok      = count_legal(w_cnt, MAX_PULSES);

   // Start requests while running are discarded entirely
   assign take_write  = req_stop || (req_start && !seq_busy);

   assign start       = req_start && !seq_busy && !locked && cnt_ok;
   assign start_cnt   = w_cnt;
   assign stop        = req_stop && seq_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (take_write) begin
         cfg_q.pol  <= wdata[BIT_POL];
         cfg_q.fast <= wdata[BIT_FAST];
         cfg_q.cnt  <= w_cnt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_err <= 1'b0;
         lock_err  <= 1'b0;
      end else if (req_start && !seq_busy) begin
         count_err <= !cnt_ok;
         lock_err  <= locked;
      end
   end

endmodule

// File: rtl/dpg_sequencer.sv
module dpg_sequencer
   import dpg_pkg::*;
#(
   parameter int unsigned SLOW_TICKS = 100,
   parameter int unsigned FAST_TICKS = 50,
   parameter int unsigned BREAK_PCT  = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] start_cnt,
   input  logic             stop,
   input  logic             fast,
   input  logic             tick,
   output dpg_phase_e       phase,
   output logic             done
);
   localparam int unsigned SLOW_BRK = (SLOW_TICKS * BREAK_PCT) / 100;
   localparam int unsigned SLOW_MAK = SLOW_TICKS - SLOW_BRK;
   localparam int unsigned FAST_BRK = (FAST_TICKS * BREAK_PCT) / 100;
   localparam int unsigned FAST_MAK = FAST_TICKS - FAST_BRK;
   localparam int PH_W = $clog2(SLOW_TICKS + 1);

   localparam logic [PH_W-1:0] SLOW_BRK_END = PH_W'(SLOW_BRK - 1);
   localparam logic [PH_W-1:0] SLOW_MAK_END = PH_W'(SLOW_MAK - 1);
   localparam logic [PH_W-1:0] FAST_BRK_END = PH_W'(FAST_BRK - 1);
   localparam logic [PH_W-1:0] FAST_MAK_END = PH_W'(FAST_MAK - 1);

   logic [PH_W-1:0]  ph_cnt;
   logic [CNT_W-1:0] left_q;
   logic [PH_W-1:0]  brk_end;
   logic [PH_W-1:0]  mak_end;

   assign brk_end = fast ? FAST_BRK_END : SLOW_BRK_END;
   assign mak_end = fast ? FAST_MAK_END : SLOW_MAK_END;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         ph_cnt <= '0;
         left_q <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (stop) begin
            phase  <= PH_IDLE;
            ph_cnt <= '0;
         end else if (start) begin
            phase  <= PH_BREAK;
            ph_cnt <= '0;
            left_q <= start_cnt;
         end else if (tick) begin
            unique case (phase)
               PH_BREAK: begin
                  if (ph_cnt == brk_end) begin
                     ph_cnt <= '0;
                     phase  <= PH_MAKE;
                  end else begin
                     ph_cnt <= ph_cnt + 1'b1;
                  end
               end
               PH_MAKE: begin
                  if (ph_cnt == mak_end) begin
                     ph_cnt <= '0;
                     if (left_q == CNT_W'(1)) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                     end else begin
                        left_q <= left_q - 1'b1;
                        phase  <= PH_BREAK;
                     end
                  end else begin
                     ph_cnt <= ph_cnt + 1'b1;
                  end
               end
               default: begin
                  ph_cnt <= '0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/dial_pulse_gen.sv
module dial_pulse_gen
   import dpg_pkg::*;
#(
   parameter int unsigned TICK_DIV   = 1000,
   parameter int unsigned SLOW_TICKS = 100,
   parameter int unsigned FAST_TICKS = 50,
   parameter int unsigned BREAK_PCT  = 60,
   parameter int unsigned MAX_PULSES = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [7:0] cfg_wdata,
   input  logic       tone_busy,
   input  logic       fsk_busy,
   output logic       pulse_out,
   output logic       busy,
   output logic       done,
   output logic       count_err,
   output logic       lock_err
);
   // Elaboration-time parameter checks
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (BREAK_PCT < 1 || BREAK_PCT > 99) begin : g_bad_pct
         $error("BREAK_PCT must lie in 1..99");
      end
      if ((FAST_TICKS * BREAK_PCT) / 100 < 1 || FAST_TICKS >= SLOW_TICKS) begin : g_bad_ticks
         $error("FAST_TICKS too small for BREAK_PCT or not below SLOW_TICKS");
      end
      if (MAX_PULSES < 1 || MAX_PULSES > (1 << CNT_W) - 1) begin : g_bad_max
         $error("MAX_PULSES must fit the count field");
      end
   endgenerate

   dpg_cfg_t         cfg_q;
   logic             start;
   logic             stop;
   logic [CNT_W-1:0] start_cnt;
   logic             tick;
   dpg_phase_e       phase;

   dpg_ctrl #(
      .MAX_PULSES (MAX_PULSES)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .wdata     (cfg_wdata),
      .seq_busy  (busy),
      .tone_busy (tone_busy),
      .fsk_busy  (fsk_busy),
      .cfg_q     (cfg_q),
      .start     (start),
      .start_cnt (start_cnt),
      .stop      (stop),
      .count_err (count_err),
      .lock_err  (lock_err)
   );

   dpg_prescaler #(
      .TICK_DIV (TICK_DIV)
   ) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start),
      .tick    (tick)
   );

   dpg_sequencer #(
      .SLOW_TICKS (SLOW_TICKS),
      .FAST_TICKS (FAST_TICKS),
      .BREAK_PCT  (BREAK_PCT)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_cnt (start_cnt),
      .stop      (stop),
      .fast      (cfg_q.fast),
      .tick      (tick),
      .phase     (phase),
      .done      (done)
   );

   logic unused_cnt;
   assign unused_cnt = ^cfg_q.cnt;

   assign busy = (phase != PH_IDLE);

   // Make is the only phase that differs from idle in positive logic
   assign pulse_out = (phase == PH_MAKE) ^ cfg_q.pol;

endmodule

// File: rtl/dpg_checker.sv
module dpg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_we,
   input logic [7:0] cfg_wdata,
   input logic       tone_busy,
   input logic       fsk_busy,
   input logic       pulse_out,
   input logic       busy,
   input logic       done,
   input logic       count_err,
   input logic       lock_err
);
   logic shadow_pol;
   logic req_idle;
   logic cnt_bad;
   logic gens_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_pol <= 1'b0;
      end else if (cfg_we && (!cfg_wdata[6] || !busy)) begin
         shadow_pol <= cfg_wdata[5];
      end
   end

   assign req_idle  = cfg_we && cfg_wdata[6] && !busy;
   assign cnt_bad   = (cfg_wdata[3:0] == 4'd0) || (cfg_wdata[3:0] > 4'd10);
   assign gens_busy = tone_busy || fsk_busy;

   // R2: accepted start shows break level next cycle
   p_start_break_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_idle && !gens_busy && !cnt_bad) |=> (busy && pulse_out == $past(cfg_wdata[5])));

   // R4: done is a single-cycle strobe at the end of the train
   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R6: idle level follows stored polarity
   p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (pulse_out == shadow_pol));

   // R7: illegal count refuses the start
   p_bad_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_idle && cnt_bad) |=> (!busy && count_err));

   // R8: busy generator refuses the start
   p_interlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_idle && gens_busy) |=> (!busy && lock_err));

   // R9: abort gives no done
   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_wdata[6] && busy) |=> (!busy && !done));

endmodule

bind dial_pulse_gen dpg_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .tone_busy (tone_busy),
   .fsk_busy  (fsk_busy),
   .pulse_out (pulse_out),
   .busy      (busy),
   .done      (done),
   .count_err (count_err),
   .lock_err  (lock_err)
);

// File: tb/sim_dial_pulse_gen.sv
module sim_dial_pulse_gen;
   localparam int DIV  = 2;
   localparam int SLOW = 100;
   localparam int FAST = 50;
   localparam int PCT  = 60;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic       tone_busy = 1'b0;
   logic       fsk_busy = 1'b0;
   logic       pulse_out, busy, done, count_err, lock_err;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dial_pulse_gen #(
      .TICK_DIV   (DIV),
      .SLOW_TICKS (SLOW),
      .FAST_TICKS (FAST),
      .BREAK_PCT  (PCT),
      .MAX_PULSES (10)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .tone_busy (tone_busy),
      .fsk_busy  (fsk_busy),
      .pulse_out (pulse_out),
      .busy      (busy),
      .done      (done),
      .count_err (count_err),
      .lock_err  (lock_err)
   );

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   // Sample from the current negedge until done; break level equals pol
   task automatic measure(input bit pol, output int pulses, output int brk_n,
                          output int mak_n, output int first_brk, output bit got_done);
      bit prev_brk = 1'b1;
      bit in_first = 1'b1;
      pulses = 0; brk_n = 0; mak_n = 0; first_brk = 0; got_done = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         if (done) begin
            got_done = 1'b1;
            break;
         end
         if (pulse_out == pol) begin
            brk_n++;
            if (in_first) first_brk++;
            prev_brk = 1'b1;
         end else begin
            mak_n++;
            in_first = 1'b0;
            if (prev_brk) pulses++;
            prev_brk = 1'b0;
         end
         @(negedge clk);
      end
   endtask

   task automatic run_train(input logic [7:0] word, input string tag);
      bit pol  = word[5];
      int per  = word[4] ? FAST : SLOW;
      int cnt  = int'(word[3:0]);
      int bexp = (per * PCT / 100) * DIV;
      int mexp = (per - per * PCT / 100) * DIV;
      int p, b, m, fb;
      bit gd;
      wr(word);
      check(busy == 1'b1 && pulse_out == pol, {tag, " R2 start break level"}, int'(pulse_out), int'(pol));
      measure(pol, p, b, m, fb, gd);
      check(gd, {tag, " R4 done seen"}, int'(gd), 1);
      check(p == cnt, {tag, " R3 pulse count"}, p, cnt);
      check(fb == bexp, {tag, " R5 first break length"}, fb, bexp);
      check(b == cnt * bexp, {tag, " R3 break cycles"}, b, cnt * bexp);
      check(m == cnt * mexp, {tag, " R3 make cycles"}, m, cnt * mexp);
      check(!busy && pulse_out == pol, {tag, " R4 idle after done"}, int'(pulse_out), int'(pol));
      @(negedge clk);
      check(!done, {tag, " R4 done one cycle"}, int'(done), 0);
   endtask

   task automatic t_reset();
      check(pulse_out == 0 && !busy && !done && !count_err && !lock_err, "R1 reset state",
            int'({pulse_out, busy, done, count_err, lock_err}), 0);
   endtask

   task automatic t_trains();
      run_train(8'h41, "pos slow x1");
      run_train(8'h53, "pos fast x3");
      run_train(8'h5A, "pos fast x10 (R3 upper)");
      run_train(8'hD1, "R10 reserved bit set");
   endtask

   task automatic t_polarity();
      wr(8'h20);
      check(pulse_out == 1'b1 && !busy, "R6 idle high when pol=1", int'(pulse_out), 1);
      run_train(8'h72, "R6 neg fast x2");
      wr(8'h00);
      check(pulse_out == 1'b0, "R6 idle low when pol=0", int'(pulse_out), 0);
   endtask

   task automatic t_bad_count();
      logic [3:0] bad [3] = '{4'd0, 4'd11, 4'd15};
      foreach (bad[k]) begin
         wr({4'h4, bad[k]});
         check(count_err && !busy && pulse_out == 0, $sformatf("R7 bad count %0d refused", bad[k]),
               int'({count_err, busy}), 2);
      end
      wr(8'h41);
      check(!count_err && busy, "R7 flag cleared by legal start", int'({count_err, busy}), 1);
      wr(8'h00);
   endtask

   task automatic t_interlock();
      tone_busy = 1'b1;
      wr(8'h41);
      check(lock_err && !busy, "R8 tone busy refuses start", int'({lock_err, busy}), 2);
      tone_busy = 1'b0;
      fsk_busy  = 1'b1;
      wr(8'h41);
      check(lock_err && !busy, "R8 fsk busy refuses start", int'({lock_err, busy}), 2);
      fsk_busy = 1'b0;
      wr(8'h41);
      check(!lock_err && busy, "R8 flag cleared when generators idle", int'({lock_err, busy}), 1);
      wr(8'h00);
   endtask

   task automatic t_abort();
      bit saw = 1'b0;
      wr(8'h43);
      repeat (150) @(negedge clk);
      check(pulse_out == 1'b1 && busy, "R9 in make interval before abort", int'(pulse_out), 1);
      wr(8'h00);
      check(!busy && pulse_out == 1'b0 && !done, "R9 abort to idle", int'({busy, pulse_out, done}), 0);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (done || busy) saw = 1'b1;
      end
      check(!saw, "R9 no done or restart after abort", int'(saw), 0);
   endtask

   task automatic t_ignore_busy_write();
      int p, b, m, fb;
      bit gd;
      wr(8'h52);
      repeat (10) @(negedge clk);
      wr(8'h65);
      check(pulse_out == 1'b0 && busy, "R11 polarity unchanged after discarded write", int'(pulse_out), 0);
      measure(1'b0, p, b, m, fb, gd);
      check(gd && p == 2, "R11 train keeps original count", p, 2);
      check(pulse_out == 1'b0, "R11 idle level unchanged", int'(pulse_out), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_trains();
      t_polarity();
      t_bad_count();
      t_interlock();
      t_abort();
      t_ignore_busy_write();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog R1..: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule